// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block performs the stack traffic of an 8-bit processor with a 16-bit program counter whenever control flow enters or leaves a handler or a subroutine. It covers six operations: software break, subroutine call, subroutine return, return from interrupt, maskable interrupt entry and non-maskable interrupt entry. A one-cycle start strobe carries an operation code and a snapshot of the program counter, the status byte, the stack pointer and, for a call, the target address. The block then issues one byte-wide memory access per clock. Stack bytes are pushed to or popped from a fixed memory page, and new program counter bytes are read from a fixed pair of vector addresses.

When the last access is done, a one-cycle done pulse marks the moment when the updated program counter, status byte and stack pointer on the outputs are final. The surrounding core copies them back into its own registers at that point. Opcode fetch, operand addressing and arithmetic belong to other blocks.

Top module: `intr_stack_seq`

## Requirements
- R1: Every stack access addresses 0x0100 plus an 8-bit pointer. A push writes at the current pointer and then decrements it. A pop first increments the pointer and then reads at the new value.
- R2: Operation codes on `op_i` are 0 break, 1 call, 2 return from interrupt, 3 subroutine return, 4 maskable interrupt and 5 non-maskable interrupt. A start is accepted only while `busy_o` is low. The first access comes in the cycle after acceptance, with one access per cycle and never a read and a write together. `done_o` is high for exactly the one cycle after the last access. `busy_o` is high from the first access through the done cycle, and a start seen while busy has no effect.
- R3: Break pushes PC high, PC low, then the unmodified status byte. It then reads the PC low byte from 0xFFFE and the high byte from 0xFFFF. The final status is the input status with bit 4 (break flag) set.
- R4: Maskable interrupt entry makes the same five accesses as break. The final status is the input status with bit 2 (interrupt mask) set.
- R5: A maskable interrupt start while status bit 2 is set is ignored. It causes no access, `busy_o` and `done_o` stay low, and `pc_o`, `status_o` and `sp_o` keep their values.
- R6: Non-maskable interrupt entry pushes PC high, PC low and status in that order. It reads the PC low byte from 0xFFFA and the high byte from 0xFFFB, and leaves the status unchanged.
- R7: Call pushes the high and then the low byte of (PC - 1) modulo 2^16. The final PC equals the target input.
- R8: Subroutine return pops the low byte and then the high byte. The final PC is the popped value plus one, modulo 2^16.
- R9: Return from interrupt pops the status, then the PC low byte, then the PC high byte. The final status and PC are the popped values, with no adjustment.
- R10: Operation codes 6 and 7 are ignored in the same way as a masked interrupt.
- R11: The stack pointer wraps modulo 256 inside the stack page on both push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| op_i | input | 3 | Operation code |
| pc_i | input | 16 | Current program counter |
| status_i | input | 8 | Current status byte |
| sp_i | input | 8 | Current stack pointer |
| target_i | input | 16 | Call target address |
| mem_addr_o | output | 16 | Memory access address |
| mem_we_o | output | 1 | Write request for this cycle |
| mem_re_o | output | 1 | Read request for this cycle |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read request |
| pc_o | output | 16 | Updated program counter |
| status_o | output | 8 | Updated status byte |
| sp_o | output | 8 | Updated stack pointer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle. The first is a fresh start request arriving while a sequence is still making its accesses. The second is the last access of one operation coinciding with the final program counter adjustment, where a popped high byte and the +1 of a subroutine return land in one register update. The bench holds the start strobe high with a different operation code for the whole of a sequence and judges that the access trace and final results match the original operation alone. It also pops 0xFFFF across the wrap of the stack pointer and expects 0x0000 with the pointer back in page order.

// File: rtl/iss_pkg.sv
package iss_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int OP_W      = 3;
  localparam int MAX_STEPS = 5;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int FLAG_I    = 2;
  localparam int FLAG_B    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_BRK = 3'd0, OP_JSR = 3'd1, OP_RTI = 3'd2,
    OP_RTS = 3'd3, OP_IRQ = 3'd4, OP_NMI = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    MU_NONE, MU_PUSH_PCH, MU_PUSH_PCL, MU_PUSH_ST,
    MU_POP_ST, MU_POP_PCL, MU_POP_PCH, MU_VEC_LO, MU_VEC_HI
  } mu_e;

  typedef enum logic [1:0] { SQ_IDLE, SQ_RUN, SQ_DONE } seq_e;

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return code <= OP_W'(OP_NMI);
  endfunction

  function automatic logic [STEP_W-1:0] op_len(input op_e op);
    case (op)
      OP_JSR, OP_RTS: return STEP_W'(2);
      OP_RTI:         return STEP_W'(3);
      default:        return STEP_W'(MAX_STEPS);
    endcase
  endfunction

  function automatic mu_e op_step(input op_e op, input logic [STEP_W-1:0] idx);
    mu_e m;
    m = MU_NONE;
    case (op)
      OP_BRK, OP_IRQ, OP_NMI: begin
        if (idx == STEP_W'(0)) m = MU_PUSH_PCH;
        else if (idx == STEP_W'(1)) m = MU_PUSH_PCL;
        else if (idx == STEP_W'(2)) m = MU_PUSH_ST;
        else if (idx == STEP_W'(3)) m = MU_VEC_LO;
        else if (idx == STEP_W'(4)) m = MU_VEC_HI;
      end
      OP_JSR: begin
        if (idx == STEP_W'(0)) m = MU_PUSH_PCH;
        else if (idx == STEP_W'(1)) m = MU_PUSH_PCL;
      end
      OP_RTS: begin
        if (idx == STEP_W'(0)) m = MU_POP_PCL;
        else if (idx == STEP_W'(1)) m = MU_POP_PCH;
      end
      OP_RTI: begin
        if (idx == STEP_W'(0)) m = MU_POP_ST;
        else if (idx == STEP_W'(1)) m = MU_POP_PCL;
        else if (idx == STEP_W'(2)) m = MU_POP_PCH;
      end
      default: m = MU_NONE;
    endcase
    return m;
  endfunction

  function automatic logic [ADDR_W-1:0] stack_addr(input logic [7:0] page,
                                                   input logic [DATA_W-1:0] ptr);
    return {page, ptr};
  endfunction

  function automatic logic [ADDR_W-1:0] vector_base(input op_e op,
                                                    input logic [ADDR_W-1:0] nmi_vec,
                                                    input logic [ADDR_W-1:0] mask_vec);
    return (op == OP_NMI) ? nmi_vec : mask_vec;
  endfunction

  function automatic logic [ADDR_W-1:0] entry_pc(input op_e op,
                                                 input logic [ADDR_W-1:0] pc);
    return (op == OP_JSR) ? pc - ADDR_W'(1) : pc;
  endfunction

  function automatic logic [ADDR_W-1:0] final_pc(input op_e op,
                                                 input logic [ADDR_W-1:0] pc,
                                                 input logic [ADDR_W-1:0] tgt);
    case (op)
      OP_JSR:  return tgt;
      OP_RTS:  return pc + ADDR_W'(1);
      default: return pc;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] final_status(input op_e op,
                                                     input logic [DATA_W-1:0] st);
    case (op)
      OP_BRK:  return st | (DATA_W'(1) << FLAG_B);
      OP_IRQ:  return st | (DATA_W'(1) << FLAG_I);
      default: return st;
    endcase
  endfunction
endpackage

// File: rtl/iss_step_decode.sv
module iss_step_decode
  import iss_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] idx,
  output mu_e               mu,
  output logic              last
);
  always_comb begin
    mu   = op_step(op, idx);
    last = (idx == op_len(op) - STEP_W'(1));
  end
endmodule

// File: rtl/iss_bus_drive.sv
module iss_bus_drive
  import iss_pkg::*;
#(
  parameter logic [7:0]        STACK_PAGE   = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI      = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_MASKABLE = 16'hFFFE
) (
  input  logic              active,
  input  mu_e               mu,
  input  op_e               op,
  input  logic [ADDR_W-1:0] wpc,
  input  logic [DATA_W-1:0] wst,
  input  logic [DATA_W-1:0] wsp,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic              re,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] pop_ptr;
  logic [ADDR_W-1:0] vec_base;

  always_comb begin
    pop_ptr  = wsp + DATA_W'(1);
    vec_base = vector_base(op, VEC_NMI, VEC_MASKABLE);
    addr  = '0;
    we    = 1'b0;
    re    = 1'b0;
    wdata = '0;
    if (active) begin
      case (mu)
        MU_PUSH_PCH: begin addr = stack_addr(STACK_PAGE, wsp); we = 1'b1; wdata = wpc[15:8]; end
        MU_PUSH_PCL: begin addr = stack_addr(STACK_PAGE, wsp); we = 1'b1; wdata = wpc[7:0];  end
        MU_PUSH_ST:  begin addr = stack_addr(STACK_PAGE, wsp); we = 1'b1; wdata = wst;       end
        MU_POP_ST, MU_POP_PCL, MU_POP_PCH: begin
          addr = stack_addr(STACK_PAGE, pop_ptr);
          re   = 1'b1;
        end
        MU_VEC_LO: begin addr = vec_base;                re = 1'b1; end
        MU_VEC_HI: begin addr = vec_base + ADDR_W'(1);   re = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iss_work_regs.sv
module iss_work_regs
  import iss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  op_e               load_op,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] st_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] tgt_in,
  input  logic              step_en,
  input  mu_e               mu,
  input  logic              last,
  input  op_e               run_op,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] st_q,
  output logic [DATA_W-1:0] sp_q
);
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] pc_s;
  logic [DATA_W-1:0] st_s;
  logic [DATA_W-1:0] sp_s;

  always_comb begin
    pc_s = pc_q;
    st_s = st_q;
    sp_s = sp_q;
    case (mu)
      MU_PUSH_PCH, MU_PUSH_PCL, MU_PUSH_ST: sp_s = sp_q - DATA_W'(1);
      MU_POP_ST:  begin sp_s = sp_q + DATA_W'(1); st_s = rdata;       end
      MU_POP_PCL: begin sp_s = sp_q + DATA_W'(1); pc_s[7:0]  = rdata; end
      MU_POP_PCH: begin sp_s = sp_q + DATA_W'(1); pc_s[15:8] = rdata; end
      MU_VEC_LO:  pc_s[7:0]  = rdata;
      MU_VEC_HI:  pc_s[15:8] = rdata;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      st_q  <= '0;
      sp_q  <= '0;
      tgt_q <= '0;
    end else if (load) begin
      pc_q  <= entry_pc(load_op, pc_in);
      st_q  <= st_in;
      sp_q  <= sp_in;
      tgt_q <= tgt_in;
    end else if (step_en) begin
      pc_q <= last ? final_pc(run_op, pc_s, tgt_q) : pc_s;
      st_q <= last ? final_status(run_op, st_s)   : st_s;
      sp_q <= sp_s;
    end
  end
endmodule

// File: rtl/intr_stack_seq.sv
module intr_stack_seq
  import iss_pkg::*;
#(
  parameter logic [7:0]        STACK_PAGE   = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI      = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_MASKABLE = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_e              state_q;
  logic [STEP_W-1:0] idx_q;
  op_e               op_q;
  op_e               op_in;
  mu_e               mu;
  logic              last;
  logic              idle;
  logic              irq_masked;
  logic              start_ok;
  logic              step_en;

  assign idle       = (state_q == SQ_IDLE);
  assign op_in      = op_e'(op_i);
  assign irq_masked = idle && start_i && (op_i == OP_W'(OP_IRQ)) && status_i[FLAG_I];
  assign start_ok   = idle && start_i && op_known(op_i) && !irq_masked;
  assign step_en    = (state_q == SQ_RUN);
  assign busy_o     = !idle;
  assign done_o     = (state_q == SQ_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      op_q    <= OP_BRK;
    end else begin
      case (state_q)
        SQ_IDLE: if (start_ok) begin
          state_q <= SQ_RUN;
          idx_q   <= '0;
          op_q    <= op_in;
        end
        SQ_RUN: begin
          if (last) begin
            state_q <= SQ_DONE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + STEP_W'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  iss_step_decode u_decode (
    .op   (op_q),
    .idx  (idx_q),
    .mu   (mu),
    .last (last)
  );

  iss_bus_drive #(
    .STACK_PAGE   (STACK_PAGE),
    .VEC_NMI      (VEC_NMI),
    .VEC_MASKABLE (VEC_MASKABLE)
  ) u_bus (
    .active (step_en),
    .mu     (mu),
    .op     (op_q),
    .wpc    (pc_o),
    .wst    (status_o),
    .wsp    (sp_o),
    .addr   (mem_addr_o),
    .we     (mem_we_o),
    .re     (mem_re_o),
    .wdata  (mem_wdata_o)
  );

  iss_work_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .load_op (op_in),
    .pc_in   (pc_i),
    .st_in   (status_i),
    .sp_in   (sp_i),
    .tgt_in  (target_i),
    .step_en (step_en),
    .mu      (mu),
    .last    (last),
    .run_op  (op_q),
    .rdata   (mem_rdata_i),
    .pc_q    (pc_o),
    .st_q    (status_o),
    .sp_q    (sp_o)
  );
endmodule

// File: rtl/iss_checker.sv
module iss_checker
  import iss_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] status_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              irq_masked,
  input logic              start_ok,
  input logic [OP_W-1:0]   run_op
);
  AST_EXCL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy_o && !done_o)); // R2
  AST_WRITE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o[15:8] == STACK_PAGE)); // R1
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (sp_o == $past(sp_o) - DATA_W'(1))); // R11
  AST_BRK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && run_op == OP_W'(OP_BRK)) |-> status_o[FLAG_B]); // R3
  AST_IRQ_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && run_op == OP_W'(OP_IRQ)) |-> status_o[FLAG_I]); // R4
  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked |=> (!busy_o && $stable(sp_o))); // R5
endmodule

bind intr_stack_seq iss_checker #(.STACK_PAGE(STACK_PAGE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o),
  .status_o   (status_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .irq_masked (irq_masked),
  .start_ok   (start_ok),
  .run_op     (op_q)
);

// File: tb/intr_stack_seq_bench.sv
`timescale 1ns/1ps
module intr_stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  status_i = '0;
  logic [7:0]  sp_i = '0;
  logic [15:0] target_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, mem_re_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic [15:0] pc_o;
  logic [7:0]  status_o, sp_o;
  logic        busy_o, done_o;

  int total = 0;
  int fails = 0;

  logic [7:0] stk [256];
  logic [7:0] vec [4];   // FFFA, FFFB, FFFE, FFFF

  always #10 clk = ~clk;

  intr_stack_seq u_intr_stack_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .pc_i(pc_i), .status_i(status_i), .sp_i(sp_i), .target_i(target_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .pc_o(pc_o), .status_o(status_o), .sp_o(sp_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always_comb begin
    mem_rdata_i = 8'h00;
    if (mem_addr_o[15:8] == 8'h01) mem_rdata_i = stk[mem_addr_o[7:0]];
    else if (mem_addr_o == 16'hFFFA) mem_rdata_i = vec[0];
    else if (mem_addr_o == 16'hFFFB) mem_rdata_i = vec[1];
    else if (mem_addr_o == 16'hFFFE) mem_rdata_i = vec[2];
    else if (mem_addr_o == 16'hFFFF) mem_rdata_i = vec[3];
  end

  always @(posedge clk)
    if (mem_we_o && mem_addr_o[15:8] == 8'h01) stk[mem_addr_o[7:0]] <= mem_wdata_o;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // expected trace
  logic [15:0] e_addr [5];
  logic        e_we   [5];
  logic [7:0]  e_wd   [5];
  int          e_n;
  logic [7:0]  e_sp;

  task automatic exp_push(input logic [7:0] v);
    e_addr[e_n] = {8'h01, e_sp}; e_we[e_n] = 1'b1; e_wd[e_n] = v;
    e_sp = e_sp - 8'd1; e_n++;
  endtask

  task automatic exp_pop(output logic [7:0] v);
    e_sp = e_sp + 8'd1;
    e_addr[e_n] = {8'h01, e_sp}; e_we[e_n] = 1'b0; e_wd[e_n] = 8'h00;
    v = stk[e_sp]; e_n++;
  endtask

  task automatic exp_read(input logic [15:0] a);
    e_addr[e_n] = a; e_we[e_n] = 1'b0; e_wd[e_n] = 8'h00; e_n++;
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R7";
      3'd2: return "R9";
      3'd3: return "R8";
      3'd4: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] st,
                        input logic [7:0] sp, input logic [15:0] tgt, input bit hold);
    logic [15:0] epc;
    logic [7:0]  est, lo, hi, ps;
    logic [15:0] p1;
    string rq;
    rq = tag_of(op);
    e_n = 0; e_sp = sp; epc = pc; est = st;
    case (op)
      3'd0, 3'd4, 3'd5: begin
        exp_push(pc[15:8]); exp_push(pc[7:0]); exp_push(st);
        if (op == 3'd5) begin
          exp_read(16'hFFFA); exp_read(16'hFFFB); epc = {vec[1], vec[0]};
        end else begin
          exp_read(16'hFFFE); exp_read(16'hFFFF); epc = {vec[3], vec[2]};
        end
        if (op == 3'd0) est = st | 8'h10;
        if (op == 3'd4) est = st | 8'h04;
      end
      3'd1: begin
        p1 = pc - 16'd1;
        exp_push(p1[15:8]); exp_push(p1[7:0]); epc = tgt;
      end
      3'd3: begin
        exp_pop(lo); exp_pop(hi); epc = {hi, lo} + 16'd1;
      end
      default: begin
        exp_pop(ps); exp_pop(lo); exp_pop(hi); epc = {hi, lo}; est = ps;
      end
    endcase
    @(negedge clk);
    start_i = 1'b1; op_i = op; pc_i = pc; status_i = st; sp_i = sp; target_i = tgt;
    for (int k = 0; k < e_n; k++) begin
      @(negedge clk);
      if (!hold) start_i = 1'b0;
      if (hold) op_i = 3'd3;
      chk(busy_o && !done_o && mem_we_o == e_we[k] && mem_re_o == !e_we[k] &&
          mem_addr_o == e_addr[k] && (!e_we[k] || mem_wdata_o == e_wd[k]),
          rq, $sformatf("access %0d {we,re,addr,wdata}", k),
          {6'd0, mem_we_o, mem_re_o, mem_addr_o, mem_wdata_o},
          {6'd0, e_we[k], !e_we[k], e_addr[k], e_wd[k]});
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && busy_o && !mem_we_o && !mem_re_o, "R2", "done pulse {done,busy}",
        {30'd0, done_o, busy_o}, 32'd3);
    chk(pc_o == epc, rq, "final pc", {16'd0, pc_o}, {16'd0, epc});
    chk(status_o == est, rq, "final status", {24'd0, status_o}, {24'd0, est});
    chk(sp_o == e_sp, "R11", "final sp", {24'd0, sp_o}, {24'd0, e_sp});
  endtask

  task automatic run_ignored(input logic [2:0] op, input logic [7:0] st, input string rq);
    logic [15:0] opc;
    logic [7:0]  ost, osp;
    @(negedge clk);
    opc = pc_o; ost = status_o; osp = sp_o;
    start_i = 1'b1; op_i = op; pc_i = $urandom; status_i = st; sp_i = $urandom;
    target_i = $urandom;
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !mem_we_o && !mem_re_o, rq, "ignored start {busy,we,re}",
        {29'd0, busy_o, mem_we_o, mem_re_o}, 32'd0);
    @(negedge clk);
    chk(!done_o && !busy_o, rq, "no done after ignored start", {31'd0, done_o}, 32'd0);
    chk(pc_o == opc && status_o == ost && sp_o == osp, rq, "outputs held",
        {pc_o, status_o, sp_o}, {opc, ost, osp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) stk[i] = 8'($urandom);
    vec[0] = 8'h34; vec[1] = 8'h12; vec[2] = 8'hCD; vec[3] = 8'hAB;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state R2
    chk(!busy_o && !done_o && !mem_we_o && !mem_re_o && pc_o == 16'd0 && sp_o == 8'd0,
        "R2", "reset state", {pc_o, sp_o, 4'd0, busy_o, done_o, mem_we_o, mem_re_o}, 32'd0);
    rst_n = 1'b1;

    // R3 R11: break with pointer wrapping below 0x00
    run_op(3'd0, 16'h8123, 8'h20, 8'h01, 16'h0000, 1'b0);
    // R8 R11: return popping 0xFFFF across wrap, pc becomes 0x0000
    stk[8'hFF] = 8'hFF; stk[8'h00] = 8'hFF;
    run_op(3'd3, 16'h5555, 8'h00, 8'hFE, 16'h0000, 1'b0);
    // R7: call at pc 0 pushes 0xFFFF
    run_op(3'd1, 16'h0000, 8'h81, 8'h80, 16'hC0DE, 1'b0);
    // R6 R2: nmi with start held and a different code presented while busy
    run_op(3'd5, 16'h4321, 8'h04, 8'hF0, 16'h0000, 1'b1);
    // R4: maskable interrupt with mask clear
    run_op(3'd4, 16'hBEEF, 8'h00, 8'h10, 16'h0000, 1'b0);
    // R5: masked interrupt ignored
    run_ignored(3'd4, 8'h04, "R5");
    run_ignored(3'd4, 8'hFF, "R5");
    // R10: unused codes ignored
    run_ignored(3'd6, 8'h00, "R10");
    run_ignored(3'd7, 8'h00, "R10");
    // R9: return from interrupt
    stk[8'h31] = 8'hC3; stk[8'h32] = 8'h78; stk[8'h33] = 8'h56;
    run_op(3'd2, 16'h0000, 8'h00, 8'h30, 16'h0000, 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] op;
      logic [7:0] st;
      op = 3'($urandom_range(0, 5));
      st = 8'($urandom);
      for (int v = 0; v < 4; v++) vec[v] = 8'($urandom);
      if (op == 3'd4 && st[2]) run_ignored(op, st, "R5");
      else run_op(op, 16'($urandom), st, 8'($urandom), 16'($urandom), n[0]);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule